// File: doc/BRIEF.md
# Nixie Display Frame Serializer

This block turns one display frame for a six-tube nixie board into the serial control stream that drives a chain of open-drain driver stages. A frame gives one 4-bit digit code per tube position and five decimal-point flags. The block packs these into a 65-bit control word, in which a 1 turns an open-drain output on and pulls its net to ground, and a 0 leaves that net floating. It then sends the word on a data line, timed by a divided shift clock, and ends with a one-cycle latch strobe that moves the shifted word onto the driver outputs.

The 65-bit word has six 10-bit tube groups followed by a 5-bit decimal-point group. Tube position p owns word bits p*10 to p*10+9. Inside a group, the slot order is digit 1 through digit 9 and then digit 0. Decimal point i owns word bit 60+i.

A test fixture can set raw mode and supply any 65-bit word. That word is shifted out unchanged, so each driver output can be switched on by itself. A frame is offered with a valid pulse. The busy output shows when the block is sending and ignores new frames.

Top module: `nixie_frame_shifter`

## Requirements
- R1: After reset, busy, serData, serClk and serLatch are all 0.
- R2: A frame is taken when loadValid is high at a clock edge while busy is low. Busy is high from the next cycle through the latch cycle, and returns low in the cycle after the latch. The frame is held inside the block, so the frame inputs may change after acceptance.
- R3: Each accepted frame produces exactly 65 rising edges of serClk, then exactly one latch pulse. The latch pulse lasts one system cycle, comes after the final falling edge of serClk, and occurs while serClk is low.
- R4: While a frame is being sent, every high phase and every low phase of serClk between two rising edges lasts exactly HALF_CYC system cycles. HALF_CYC is at least 2.
- R5: serData changes only while serClk is low. It is stable for at least one cycle before each rising edge and during the whole high phase. The n-th rising edge (n = 1..65) carries word bit 65-n, so word bit 64 goes first and word bit 0 goes last.
- R6: In digit mode, code d in 1..9 at position p sets word bit p*10+d-1, and code 0 sets word bit p*10+9. Every other bit of the group is 0.
- R7: In digit mode, a position whose code is 10..15 (15 is the normal blank code) sets no bit in its group.
- R8: Decimal-point flag i (dpFlags bit i) sets word bit 60+i.
- R9: When rawMode is high at acceptance, rawWord bit k is sent as word bit k, with no change to any bit.
- R10: A loadValid pulse while busy is high is ignored. The frame already being sent is neither changed nor restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | Offers the frame inputs for capture |
| rawMode | input | 1 | 1: send rawWord; 0: build the word from digits and flags |
| digitCodes | input | 24 | 4-bit code per position; position p in bits 4p+3..4p |
| dpFlags | input | 5 | Decimal-point enables; bit i maps to word bit 60+i |
| rawWord | input | 65 | Override word, sent unchanged in raw mode |
| busy | output | 1 | High while a frame is being sent and latched |
| serData | output | 1 | Serial control data |
| serClk | output | 1 | Shift clock; data is sampled on its rising edge |
| serLatch | output | 1 | One-cycle strobe that transfers the shifted word |

## Verification
The assertions check the serial timing on every cycle:
- data holds steady across each high phase and in the cycle before each rising edge;
- the clock has a minimum high and low width;
- the latch pulse lasts one cycle and occurs with the clock low;
- the clock and latch appear only while busy;
- busy falls only after a latch;
- exactly 65 rising edges come before every latch.

Only the bench scenarios can show that the word content is correct. To do this, the bench rebuilds the 65-bit word from the captured stream and compares it with a word computed independently. This covers the digit-to-slot mapping, the handling of blank codes, decimal-point placement, raw-mode pass-through, the first-bit and last-bit order, and the rejection of a frame offered while busy.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LATCH
  } nfs_state_t;

  typedef struct packed {
    logic load;
    logic shift;
  } nfs_strobe_t;
endpackage

// File: rtl/nfs_datapath.sv
module nfs_datapath
  import nfs_pkg::*;
#(
  parameter int NUM_POS = 6,
  parameter int NUM_DP  = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  nfs_strobe_t                         strobe,
  input  logic                                rawMode,
  input  logic [NUM_POS*4-1:0]                digitCodes,
  input  logic [NUM_DP-1:0]                   dpFlags,
  input  logic [NUM_POS*10+NUM_DP-1:0]        rawWord,
  output logic                                serData
);
  localparam int SLOTS  = 10;
  localparam int CODE_W = 4;
  localparam int WORD_W = NUM_POS*SLOTS + NUM_DP;

  logic [WORD_W-1:0] digitWord;
  logic [WORD_W-1:0] shiftReg;

  // Each group slot compares its own position's code with the digit it stands for.
  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam logic [CODE_W-1:0] SLOT_DIGIT = (s == SLOTS-1) ? CODE_W'(0) : CODE_W'(s+1);
      assign digitWord[p*SLOTS+s] = (digitCodes[p*CODE_W +: CODE_W] == SLOT_DIGIT);
    end
  end

  for (genvar i = 0; i < NUM_DP; i++) begin : g_dp
    assign digitWord[NUM_POS*SLOTS+i] = dpFlags[i];
  end

  // The most significant bit leaves first, and zeros are shifted in behind it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= rawMode ? rawWord : digitWord;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serData = shiftReg[WORD_W-1];
endmodule

// File: rtl/nfs_ctrl.sv
module nfs_ctrl
  import nfs_pkg::*;
#(
  parameter int WORD_W   = 65,
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadValid,
  output nfs_strobe_t strobe,
  output logic        busy,
  output logic        serClk,
  output logic        serLatch
);
  localparam int PH_W  = $clog2(HALF_CYC + 1);
  localparam int CNT_W = $clog2(WORD_W + 1);

  nfs_state_t       state;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == PH_W'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (loadValid) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
            bitCnt   <= '0;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            state    <= (bitCnt == CNT_W'(WORD_W)) ? ST_LATCH : ST_HIGH;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            bitCnt   <= bitCnt + 1'b1;
            state    <= ST_LOW;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_LATCH: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == ST_IDLE) && loadValid;
    strobe.shift = (state == ST_HIGH) && phaseEnd;
  end

  assign busy     = (state != ST_IDLE);
  assign serClk   = (state == ST_HIGH);
  assign serLatch = (state == ST_LATCH);
endmodule

// File: rtl/nixie_frame_shifter.sv
module nixie_frame_shifter
  import nfs_pkg::*;
#(
  parameter int NUM_POS  = 6,
  parameter int NUM_DP   = 5,
  parameter int HALF_CYC = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         loadValid,
  input  logic                         rawMode,
  input  logic [NUM_POS*4-1:0]         digitCodes,
  input  logic [NUM_DP-1:0]            dpFlags,
  input  logic [NUM_POS*10+NUM_DP-1:0] rawWord,
  output logic                         busy,
  output logic                         serData,
  output logic                         serClk,
  output logic                         serLatch
);
  localparam int WORD_W = NUM_POS*10 + NUM_DP;

  nfs_strobe_t strobe;

  nfs_ctrl #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .strobe(strobe),
    .busy(busy), .serClk(serClk), .serLatch(serLatch)
  );

  nfs_datapath #(.NUM_POS(NUM_POS), .NUM_DP(NUM_DP)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rawMode(rawMode),
    .digitCodes(digitCodes), .dpFlags(dpFlags), .rawWord(rawWord),
    .serData(serData)
  );
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
  parameter int WORD_W = 65
) (
  input logic clk,
  input logic rst_n,
  input logic loadValid,
  input logic busy,
  input logic serData,
  input logic serClk,
  input logic serLatch
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  logic [CNT_W-1:0] riseCnt;
  logic             clkPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      riseCnt <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkPrev <= serClk;
      if (loadValid && !busy) riseCnt <= '0;
      else if (serClk && !clkPrev) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R5
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serClk && $past(serClk)) |-> $stable(serData));
  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serClk) |-> $stable(serData));
  // R4
  min_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serClk) |=> serClk);
  // R4
  min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serClk) |=> !serClk);
  // R3
  latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serLatch |=> !serLatch);
  // R3
  latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serLatch |-> !serClk);
  // R3
  latch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serLatch |-> (riseCnt == CNT_W'(WORD_W)));
  // R2
  activity_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serClk || serLatch) |-> busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(serLatch));
endmodule

bind nixie_frame_shifter nfs_checker #(.WORD_W(NUM_POS*10+NUM_DP)) chk_i (
  .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .busy(busy),
  .serData(serData), .serClk(serClk), .serLatch(serLatch)
);

// File: tb/nixie_frame_shifter_tb.sv
module nixie_frame_shifter_tb_top;
  localparam int NUM_POS = 6;
  localparam int NUM_DP  = 5;
  localparam int HALF    = 3;
  localparam int WORD_W  = NUM_POS*10 + NUM_DP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadValid = 1'b0;
  logic rawMode = 1'b0;
  logic [NUM_POS*4-1:0] digitCodes = '0;
  logic [NUM_DP-1:0]    dpFlags = '0;
  logic [WORD_W-1:0]    rawWord = '0;
  logic busy, serData, serClk, serLatch;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nixie_frame_shifter #(.NUM_POS(NUM_POS), .NUM_DP(NUM_DP), .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .rawMode(rawMode),
    .digitCodes(digitCodes), .dpFlags(dpFlags), .rawWord(rawWord),
    .busy(busy), .serData(serData), .serClk(serClk), .serLatch(serLatch)
  );

  // Stream monitor, sampled away from the active edge
  logic [WORD_W-1:0] captured = '0;
  int riseTotal = 0, latchTotal = 0, widthErr = 0, dataErr = 0, latchErr = 0;
  int highRun = 0, lowRun = 0;
  bit lowValid = 0, prevClk = 0, prevData = 0, prevLatch = 0;

  always @(negedge clk) begin
    if (serClk) begin
      if (!prevClk) begin
        riseTotal++;
        captured = {captured[WORD_W-2:0], serData};
        if (lowValid && lowRun != HALF) widthErr++;
        if (serData != prevData) dataErr++;
        highRun = 1;
      end else begin
        highRun++;
        if (serData != prevData) dataErr++;
      end
    end else begin
      if (prevClk) begin
        if (highRun != HALF) widthErr++;
        lowRun = 1;
        lowValid = 1;
      end else begin
        lowRun++;
      end
    end
    if (serLatch) begin
      latchTotal++;
      lowValid = 0;
      if (prevLatch || serClk || !prevClk && lowRun < HALF) latchErr++;
    end
    prevClk = serClk;
    prevData = serData;
    prevLatch = serLatch;
  end

  task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] modelWord(input logic [NUM_POS*4-1:0] codes,
      input logic [NUM_DP-1:0] dp, input bit raw, input logic [WORD_W-1:0] rw);
    logic [WORD_W-1:0] w = '0;
    if (raw) return rw;
    for (int p = 0; p < NUM_POS; p++) begin
      int code = int'(codes[p*4 +: 4]);
      if (code == 0) w[p*10+9] = 1'b1;
      else if (code <= 9) w[p*10+code-1] = 1'b1;
    end
    for (int i = 0; i < NUM_DP; i++) w[60+i] = dp[i];
    return w;
  endfunction

  task automatic waitIdle();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // Offers a frame, scrambles the inputs after acceptance, and checks the received stream
  task automatic runFrame(input logic [NUM_POS*4-1:0] codes, input logic [NUM_DP-1:0] dp,
                          input bit raw, input logic [WORD_W-1:0] rw, input string req);
    int r0 = riseTotal, l0 = latchTotal;
    int w0 = widthErr, d0 = dataErr, e0 = latchErr;
    logic [WORD_W-1:0] exp = modelWord(codes, dp, raw, rw);
    @(negedge clk);
    digitCodes = codes; dpFlags = dp; rawMode = raw; rawWord = rw; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
    chk(busy == 1'b1, {"R2 busy after accept ", req}, WORD_W'(busy), WORD_W'(1));
    digitCodes = ~codes; dpFlags = ~dp; rawMode = ~raw; rawWord = ~rw;
    waitIdle();
    chk(captured == exp, {"R5 word ", req}, captured, exp);
    chk(riseTotal - r0 == WORD_W, {"R3 rising edges ", req},
        WORD_W'(riseTotal - r0), WORD_W'(WORD_W));
    chk(latchTotal - l0 == 1, {"R3 latch pulses ", req},
        WORD_W'(latchTotal - l0), WORD_W'(1));
    chk(widthErr == w0, {"R4 phase widths ", req}, WORD_W'(widthErr - w0), '0);
    chk(dataErr == d0 && latchErr == e0, {"R5 data/latch timing ", req},
        WORD_W'(dataErr - d0 + latchErr - e0), '0);
  endtask

  task automatic testReset();
    chk(busy == 0, "R1 busy", WORD_W'(busy), '0);
    chk(serData == 0, "R1 serData", WORD_W'(serData), '0);
    chk(serClk == 0, "R1 serClk", WORD_W'(serClk), '0);
    chk(serLatch == 0, "R1 serLatch", WORD_W'(serLatch), '0);
  endtask

  task automatic testDigits();
    // R6 all zero digits, then a 1..6 pattern, then all nines with every point lit (R8)
    runFrame('0, '0, 1'b0, '0, "R6 zeros");
    runFrame({4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1}, '0, 1'b0, '0, "R6 one-to-six");
    runFrame({6{4'd9}}, 5'b11111, 1'b0, '0, "R8 nines all points");
    runFrame({4'd7, 4'd0, 4'd8, 4'd2, 4'd9, 4'd3}, 5'b01010, 1'b0, '0, "R8 mixed points");
  endtask

  task automatic testBlank();
    // R7 codes 15, 12 and 10 leave their groups empty
    runFrame({4'd15, 4'd12, 4'd5, 4'd10, 4'd15, 4'd1}, 5'b00001, 1'b0, '0, "R7 blanks");
  endtask

  task automatic testRaw();
    logic [WORD_W-1:0] pat;
    // R9 a lone first-sent bit, a lone last-sent bit, and a dense pattern
    runFrame('0, '0, 1'b1, WORD_W'(1), "R9 raw bit0");
    runFrame({6{4'd3}}, 5'b11111, 1'b1, {1'b1, 64'd0}, "R9 raw bit64");
    for (int k = 0; k < WORD_W; k++) pat[k] = (k % 3 == 1);
    runFrame('0, '0, 1'b1, pat, "R9 raw pattern");
  endtask

  task automatic testBusyIgnore();
    logic [NUM_POS*4-1:0] codesA = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
    logic [WORD_W-1:0] expA = modelWord(codesA, 5'b00100, 1'b0, '0);
    int r0 = riseTotal, l0 = latchTotal;
    @(negedge clk);
    digitCodes = codesA; dpFlags = 5'b00100; rawMode = 1'b0; loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
    repeat (20) @(negedge clk);
    digitCodes = {6{4'd8}}; dpFlags = 5'b11011; rawMode = 1'b1; rawWord = '1;
    loadValid = 1'b1;
    repeat (3) @(negedge clk);
    loadValid = 1'b0;
    waitIdle();
    chk(captured == expA, "R10 frame unchanged", captured, expA);
    chk(riseTotal - r0 == WORD_W, "R10 no restart edges",
        WORD_W'(riseTotal - r0), WORD_W'(WORD_W));
    chk(latchTotal - l0 == 1, "R10 single latch", WORD_W'(latchTotal - l0), WORD_W'(1));
    repeat (3) @(negedge clk);
    chk(busy == 0, "R2 idle after frame", WORD_W'(busy), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testDigits();
    testBlank();
    testRaw();
    testBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule